// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the transmit half of a descriptor-driven network controller. Software builds a ring of four-word descriptors in memory, each 16 bytes apart, tells the engine where the ring starts, and rings a doorbell. The engine then walks the ring. For each descriptor that hardware owns, it fetches the buffer address, reads the frame out of memory one 32-bit word at a time, and hands the bytes to a MAC over a valid/ready byte stream. When the frame is done, it writes the status word back with ownership cleared and raises a completion flag. Software learns that a frame is finished by watching the ownership bit in memory or by watching the interrupt flags.

Descriptor word layout, as offsets from the descriptor start: +0 status/length, +4 VLAN tag (not read), +8 buffer address low, +12 buffer address high (not read). Status bits: 31 = hardware owns, 30 = end of ring, 29 = first segment, 28 = last segment, 12:0 = frame length in bytes.

The engine keeps polling the ring after each frame until it reads a descriptor that software still owns. It then stops, raises a descriptor-unavailable flag, and waits for the next doorbell. Register writes use a 2-bit select: 0 = ring base, 1 = doorbell, 2 = interrupt-flag clear.

Top module: `txd_poll_engine`

## Requirements
- R1: After reset, irq_status is 0, mem_req is low and tx_valid is low.
- R2: A write with select 0 while idle sets the ring base to reg_wdata with bits 7:0 forced to zero, and resets the descriptor index to 0. The same write while the engine is busy has no effect.
- R3: A write with select 1 while idle starts a fetch of the status word at ring base + 16 × index, but only when reg_wdata bit 6 is 1. With bit 6 at 0 no memory access starts.
- R4: If a fetched status word has bit 31 clear, the engine goes idle and sets irq_status bit 7. The index does not move, so the next doorbell fetches the same descriptor.
- R5: For an owned descriptor with bits 29 and 28 both set and a non-zero length, the engine reads the buffer address at descriptor + 8. It then streams exactly length bytes from that address, taking byte lanes in little-endian order and starting at lane addr[1:0].
- R6: tx_last is high only on the final byte of a frame. tx_valid, tx_data and tx_last stay stable until tx_ready accepts the byte.
- R7: In the cycle after the last byte is accepted, the engine writes the status word back to descriptor + 0 with bit 31 cleared and all other bits unchanged. Completion of that write sets irq_status bit 2.
- R8: An owned descriptor without both bits 29 and 28 set, or with length 0, sends no bytes. Its status is written back with bit 31 cleared, and irq_status bit 3 is set.
- R9: After each write-back the index advances by one. If status bit 30 was set, the index returns to 0 instead. The next descriptor is then fetched without a new doorbell.
- R10: mem_req, once high, holds mem_addr, mem_we and mem_wdata stable until mem_ack is seen.
- R11: A write with select 2 clears every irq_status bit whose reg_wdata bit is 1.
- R12: A doorbell written while the engine is busy starts no extra memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 ring base, 1 doorbell, 2 flag clear |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte valid toward MAC |
| tx_ready | input | 1 | MAC accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| irq_status | output | 8 | Flags: bit 2 sent, bit 3 error, bit 7 unavailable |

## Verification
The assertions check, on every cycle, the handshake rules that hold cycle by cycle: memory requests stay stable until they are acknowledged, and a stalled output byte stays stable. They also check that a last byte is always followed by a status write, that flags set when they are signalled, and that ring-base loads and end-of-ring wraps land on the expected address. Only the bench's scenarios can show the rest. That covers frame contents and lane order for unaligned buffers, the exact addresses fetched, and the value written back. It also covers a chain of frames ending in a wrap, error descriptors that produce no bytes, and register writes that must be ignored while the engine is busy.

// File: rtl/txd_pkg.sv
package txd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STATUS,
        ST_BUFPTR,
        ST_WORD,
        ST_SEND,
        ST_WBACK
    } txd_state_e;

    localparam int OWN_BIT   = 31;
    localparam int EOR_BIT   = 30;
    localparam int FIRST_BIT = 29;
    localparam int LAST_BIT  = 28;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_POLL = 2'd1;
    localparam logic [1:0] SEL_ICLR = 2'd2;
    localparam int         POLL_BIT = 6;

    localparam int FLAG_OK    = 2;
    localparam int FLAG_ERR   = 3;
    localparam int FLAG_UNAV  = 7;
    localparam int FLAG_W     = 8;
endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_base,
    input  logic [23:0] base_in,
    input  logic        advance,
    input  logic        wrap,
    output logic [31:0] desc_addr
);
    localparam int PAD_W = 32 - IDX_W - 4;

    typedef struct packed {
        logic [23:0]      base;
        logic [IDX_W-1:0] idx;
    } ring_t;

    ring_t q, d;

    always_comb begin
        d = q;
        if (load_base) begin
            d.base = base_in;
            d.idx  = '0;
        end else if (advance) begin
            d.idx = wrap ? '0 : q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign desc_addr = {q.base, 8'h00} + {{PAD_W{1'b0}}, q.idx, 4'b0000};

    a_r2_base_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_base |=> desc_addr == {$past(base_in), 8'h00});

    a_r9_eor_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap && !load_base) |=> desc_addr == {q.base, 8'h00});
endmodule

// File: rtl/txd_lane_sel.sv
module txd_lane_sel #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0]         word,
    input  logic [$clog2(LANES)-1:0]   lane,
    output logic [7:0]                 byte_out
);
    logic [7:0] lanes_arr [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_arr[g] = word[g*8 +: 8];
    end

    assign byte_out = lanes_arr[lane];
endmodule

// File: rtl/txd_irq_flags.sv
module txd_irq_flags
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_ok,
    input  logic              set_err,
    input  logic              set_unav,
    input  logic              clr_en,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_en) flags_d = flags_d & ~clr_mask;
        if (set_ok)   flags_d[FLAG_OK]   = 1'b1;
        if (set_err)  flags_d[FLAG_ERR]  = 1'b1;
        if (set_unav) flags_d[FLAG_UNAV] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    a_r7_ok_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_ok |=> flags[FLAG_OK]);

    a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> flags[FLAG_ERR]);

    a_r4_unav_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_unav |=> flags[FLAG_UNAV]);
endmodule

// File: rtl/txd_poll_engine.sv
module txd_poll_engine
    import txd_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic [7:0]  irq_status
);
    typedef struct packed {
        txd_state_e       st;
        logic [31:0]      sts;
        logic [31:0]      waddr;
        logic [1:0]       lane;
        logic [LEN_W-1:0] left;
        logic [31:0]      word;
        logic             bad;
    } eng_t;

    eng_t q, d;

    logic        ring_load, ring_adv, ring_wrap;
    logic [31:0] desc_addr;
    logic        set_ok, set_err, set_unav;
    logic        poll_hit, clr_hit;
    logic [LEN_W-1:0] rd_len;

    assign poll_hit  = reg_wr_en && reg_sel == SEL_POLL && reg_wdata[POLL_BIT];
    assign clr_hit   = reg_wr_en && reg_sel == SEL_ICLR;
    assign ring_load = reg_wr_en && reg_sel == SEL_BASE && q.st == ST_IDLE;
    assign rd_len    = mem_rdata[LEN_W-1:0];

    always_comb begin
        d         = q;
        ring_adv  = 1'b0;
        ring_wrap = 1'b0;
        set_ok    = 1'b0;
        set_err   = 1'b0;
        set_unav  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (poll_hit) d.st = ST_STATUS;
            end
            ST_STATUS: begin
                if (mem_ack) begin
                    d.sts = mem_rdata;
                    if (!mem_rdata[OWN_BIT]) begin
                        set_unav = 1'b1;
                        d.st     = ST_IDLE;
                    end else if (!(mem_rdata[FIRST_BIT] && mem_rdata[LAST_BIT])
                                 || rd_len == '0) begin
                        d.bad = 1'b1;
                        d.st  = ST_WBACK;
                    end else begin
                        d.bad = 1'b0;
                        d.st  = ST_BUFPTR;
                    end
                end
            end
            ST_BUFPTR: begin
                if (mem_ack) begin
                    d.waddr = mem_rdata;
                    d.lane  = mem_rdata[1:0];
                    d.left  = q.sts[LEN_W-1:0];
                    d.st    = ST_WORD;
                end
            end
            ST_WORD: begin
                if (mem_ack) begin
                    d.word = mem_rdata;
                    d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    d.left = q.left - 1'b1;
                    if (q.left == LEN_W'(1)) begin
                        d.st = ST_WBACK;
                    end else if (q.lane == 2'd3) begin
                        d.lane  = 2'd0;
                        d.waddr = {q.waddr[31:2] + 30'd1, 2'b00};
                        d.st    = ST_WORD;
                    end else begin
                        d.lane = q.lane + 2'd1;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    set_ok    = !q.bad;
                    set_err   = q.bad;
                    ring_adv  = 1'b1;
                    ring_wrap = q.sts[EOR_BIT];
                    d.st      = ST_STATUS;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = q.sts & ~(32'd1 << OWN_BIT);
        unique case (q.st)
            ST_STATUS: mem_req = 1'b1;
            ST_BUFPTR: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + 32'd8;
            end
            ST_WORD: begin
                mem_req  = 1'b1;
                mem_addr = {q.waddr[31:2], 2'b00};
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_valid = q.st == ST_SEND;
    assign tx_last  = tx_valid && q.left == LEN_W'(1);

    txd_ring_ptr #(.IDX_W(IDX_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (ring_load),
        .base_in   (reg_wdata[31:8]),
        .advance   (ring_adv),
        .wrap      (ring_wrap),
        .desc_addr (desc_addr)
    );

    txd_lane_sel #(.LANES(4)) u_lane (
        .word     (q.word),
        .lane     (q.lane),
        .byte_out (tx_data)
    );

    txd_irq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ok   (set_ok),
        .set_err  (set_err),
        .set_unav (set_unav),
        .clr_en   (clr_hit),
        .clr_mask (reg_wdata[FLAG_W-1:0]),
        .flags    (irq_status)
    );

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_we) && $stable(mem_wdata));

    a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    a_r7_wb_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> mem_req && mem_we);

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && mem_req));
endmodule

// File: tb/txd_poll_engine_test.sv
module txd_poll_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        tx_valid, tx_ready = 1'b0, tx_last;
    logic [7:0]  tx_data, irq_status;

    int checks = 0;
    int fails = 0;
    int lat = 0;
    int wait_cnt = 0;
    int slow = 0;
    int cyc = 0;

    logic [31:0] mem_words [int unsigned];
    logic [31:0] rd_log[$];
    logic [63:0] wb_log[$];
    logic [8:0]  exp_q[$];

    always #10 clk = ~clk;

    txd_poll_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .irq_status(irq_status)
    );

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (mem_words.exists(a >> 2)) return mem_words[a >> 2];
        return 32'h0;
    endfunction

    task automatic wr_word(input logic [31:0] a, input logic [31:0] v);
        mem_words[a >> 2] = v;
    endtask

    task automatic put_byte(input logic [31:0] a, input logic [7:0] b);
        logic [31:0] w;
        w = rd_word(a);
        w[8*a[1:0] +: 8] = b;
        mem_words[a >> 2] = w;
    endtask

    function automatic logic [7:0] get_byte(input logic [31:0] a);
        logic [31:0] w;
        w = rd_word(a);
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: expected frame bytes from the bench's memory
    task automatic push_frame(input logic [31:0] a, input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) put_byte(a + 32'(i), seed + 8'(i * 7));
        for (int i = 0; i < len; i++) exp_q.push_back({(i == len - 1), get_byte(a + 32'(i))});
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = s;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_unav();
        while (!irq_status[7]) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                if (wait_cnt >= lat) begin
                    mem_ack  = 1'b1;
                    wait_cnt = 0;
                    lat      = (lat + 1) % 3;
                    if (mem_we) begin
                        wr_word(mem_addr, mem_wdata);
                        wb_log.push_back({mem_addr, mem_wdata});
                    end else begin
                        mem_rdata = rd_word(mem_addr);
                        rd_log.push_back(mem_addr);
                    end
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = (slow == 0) ? 1'b1 : (cyc % 3 != 0);
            #1;
            if (rst_n && tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected byte", {55'd0, tx_last, tx_data}, 64'd0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({tx_last, tx_data} == e, "R5/R6 byte", {tx_last, tx_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(irq_status == 8'h00, "R1 irq", irq_status, 0);
        chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        rst_n = 1'b1;

        // scenario 1: one frame from an unaligned buffer, then an unowned descriptor
        wr_word(32'h1000, 32'hB000_0005);
        wr_word(32'h1008, 32'h0000_2001);
        wr_word(32'h1010, 32'h0000_0000);
        push_frame(32'h2001, 5, 8'h11);
        reg_write(2'd0, 32'h0000_1034);
        reg_write(2'd1, 32'h0000_0040);
        wait_unav();
        chk(rd_log.size() == 5, "R3 read count", rd_log.size(), 5);
        chk(rd_log[0] == 32'h1000, "R2 aligned base fetch", rd_log[0], 32'h1000);
        chk(rd_log[1] == 32'h1008, "R5 buffer pointer read", rd_log[1], 32'h1008);
        chk(exp_q.size() == 0, "R5 all bytes sent", exp_q.size(), 0);
        chk(wb_log.size() == 1, "R7 one write-back", wb_log.size(), 1);
        chk(wb_log[0] == {32'h1000, 32'h3000_0005}, "R7 write-back value", wb_log[0],
            {32'h1000, 32'h3000_0005});
        chk(irq_status == 8'h84, "R7 ok and unavailable flags", irq_status, 8'h84);
        chk(rd_log[4] == 32'h1010, "R9 next descriptor fetched", rd_log[4], 32'h1010);

        reg_write(2'd2, 32'h0000_00FF);
        chk(irq_status == 8'h00, "R11 flags cleared", irq_status, 0);

        // scenario 2: doorbell without bit 6, then a frame, an error descriptor, a wrap
        rd_log.delete();
        wb_log.delete();
        wr_word(32'h1010, 32'hB000_0008);
        wr_word(32'h1018, 32'h0000_3000);
        wr_word(32'h1020, 32'hE000_0004);
        wr_word(32'h1028, 32'h0000_4000);
        reg_write(2'd1, 32'h0000_00BF);
        repeat (20) @(negedge clk);
        chk(rd_log.size() == 0, "R3 no fetch without bit 6", rd_log.size(), 0);
        push_frame(32'h3000, 8, 8'h40);
        reg_write(2'd1, 32'h0000_0040);
        wait_unav();
        chk(rd_log[0] == 32'h1010, "R4 same descriptor refetched", rd_log[0], 32'h1010);
        chk(wb_log.size() == 2, "R8 two write-backs", wb_log.size(), 2);
        chk(wb_log[1] == {32'h1020, 32'h6000_0004}, "R8 error write-back", wb_log[1],
            {32'h1020, 32'h6000_0004});
        chk(irq_status == 8'h8C, "R8 error flag", irq_status, 8'h8C);
        chk(rd_log[rd_log.size()-1] == 32'h1000, "R9 end-of-ring wrap",
            rd_log[rd_log.size()-1], 32'h1000);
        chk(exp_q.size() == 0, "R5 frame complete", exp_q.size(), 0);

        // scenario 3: slow sink, register writes while busy, one-byte frame
        reg_write(2'd2, 32'h0000_008C);
        rd_log.delete();
        wb_log.delete();
        slow = 1;
        wr_word(32'h1000, 32'hB000_0028);
        wr_word(32'h1008, 32'h0000_5002);
        wr_word(32'h1010, 32'hB000_0001);
        wr_word(32'h1018, 32'h0000_6003);
        wr_word(32'h1020, 32'h0000_0000);
        push_frame(32'h5002, 40, 8'h80);
        push_frame(32'h6003, 1, 8'h5A);
        reg_write(2'd1, 32'h0000_0040);
        while (!tx_valid) @(negedge clk);
        reg_write(2'd0, 32'h0000_9000);
        reg_write(2'd1, 32'h0000_0040);
        wait_unav();
        chk(rd_log.size() == 17, "R12 no extra fetch", rd_log.size(), 17);
        chk(rd_log[rd_log.size()-1] == 32'h1020, "R2 base write ignored while busy",
            rd_log[rd_log.size()-1], 32'h1020);
        chk(exp_q.size() == 0, "R6 frames complete", exp_q.size(), 0);
        chk(irq_status == 8'h84, "R7 flags", irq_status, 8'h84);

        // scenario 4: zero-length owned descriptor
        slow = 0;
        reg_write(2'd2, 32'h0000_0084);
        wb_log.delete();
        wr_word(32'h1020, 32'hF000_0000);
        wr_word(32'h1000, 32'h0000_0000);
        reg_write(2'd1, 32'h0000_0040);
        wait_unav();
        chk(irq_status == 8'h88, "R8 zero length is an error", irq_status, 8'h88);
        chk(wb_log.size() == 1 && wb_log[0] == {32'h1020, 32'h7000_0000},
            "R8 zero length write-back", wb_log[0], {32'h1020, 32'h7000_0000});
        chk(exp_q.size() == 0, "R8 no bytes", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule